// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the software-facing side of a block-hash accelerator that computes SHA-1 or MD5. It decodes a 32-bit word-addressed register bus and sequences one chunk of input at a time. Software programs a control word with the algorithm, the chunk length in bytes and two per-chunk options: start from the algorithm's initial constants, and close the hash with padding. The block then raises an input-ready flag and collects data words, written by the CPU or by a DMA engine. It hands the whole chunk to an external compression core over a simple start/done handshake. When the core reports completion, the new digest lands in the digest registers, the running byte count advances, and an output-ready flag is raised. The flag can drive a level interrupt.

A hash may span several chunks, and software may put a hash aside and resume it later. To do so it rewrites the digest words and the byte count, then starts the next chunk with the initial-constants option clear. A soft reset, requested through the mask register, clears the engine. A status bit reports when that reset is over.

Top module: `hashfe_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 1, the revision register reads REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0, and irq and dma_req are low.
- R2: The register offsets are fixed as follows. Digest word i is at 0x00+4*i for i from 0 to 4. The byte count is at 0x14 and control is at 0x18. The data window covers sixteen words from 0x1C. Revision is at 0x5C, mask at 0x60 and status at 0x64. The control fields are: bit 0 output-ready, bit 1 input-ready, bit 2 algorithm (1 = SHA-1, 0 = MD5), bit 3 load initial constants, bit 4 close with padding, and bits 31:5 the chunk length in bytes.
- R3: A control write while idle latches all fields. With a nonzero length, input-ready reads 1 from the next cycle on. With a zero length, the engine stays idle and input-ready stays 0.
- R4: A chunk expects the length rounded up to whole words, capped at BLK_WORDS. Each write anywhere in the data window fills the next word in order. Slots that are never written are zero, and writes beyond the expected count are ignored. The cycle after the last expected word, input-ready is 0 and core_start is high for exactly one cycle.
- R5: core_init follows bit 3. core_count is 0 when bit 3 is set and otherwise the byte-count register. On completion the byte-count register becomes core_count plus the chunk length.
- R6: For SHA-1, digest words cross between the registers and the core byte-reversed, and all five words are updated. For MD5 they pass unchanged, four words are updated and word 4 keeps its value.
- R7: core_done sets output-ready at the next edge. irq equals output-ready AND mask bit 2. Writing 1 to control bit 0 clears output-ready.
- R8: dma_req is high while the engine awaits data words and mask bit 3 is set. It is low otherwise.
- R9: Control writes while a chunk is in progress leave every control field unchanged.
- R10: Writing 1 to mask bit 1 starts a soft reset. Status bit 0 reads 0 for RST_CYCLES cycles, then 1. Control, digest, byte count and mask end up cleared, and mask bit 1 reads 0.
- R11: core_algo and core_close follow control bits 2 and 4 of the chunk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt for output-ready |
| dma_req | output | 1 | Request for data words |
| core_start | output | 1 | One-cycle chunk start to the core |
| core_algo | output | 1 | 1 = SHA-1, 0 = MD5 |
| core_init | output | 1 | Start from the initial constants |
| core_close | output | 1 | Pad and close after this chunk |
| core_len | output | 27 | Chunk length in bytes |
| core_count | output | 32 | Bytes hashed before this chunk |
| core_digest_in | output | 160 | Restored digest in core order |
| core_block | output | 32*BLK_WORDS | Chunk data, word 0 lowest |
| core_done | input | 1 | One-cycle completion from the core |
| core_digest_out | input | 160 | New digest in core order |

## Verification
Register reads are combinational, so the effect of a write shows up on the bus one edge after the write is taken. The bench drives and samples on the falling edge, which means every read-back lands in the cycle the change is due. core_start and the drop of input-ready are due one edge after the last data word, and the bench checks both at that falling edge and again one cycle later. Output-ready, the digest and the byte count are due one edge after the core stub's done pulse, so the bench reads them only after the stub's fixed latency has passed. The soft-reset status is checked one cycle before and in the exact cycle that RST_CYCLES says it returns.

// File: rtl/hashfe_pkg.sv
package hashfe_pkg;
   localparam int DIG_WORDS = 5;
   localparam int LEN_W     = 27;
   localparam int WIN_WORDS = 16;

   localparam logic [7:0] OFS_DIGEST = 8'h00;
   localparam logic [7:0] OFS_COUNT  = 8'h14;
   localparam logic [7:0] OFS_CTRL   = 8'h18;
   localparam logic [7:0] OFS_DIN    = 8'h1C;
   localparam logic [7:0] OFS_REV    = 8'h5C;
   localparam logic [7:0] OFS_MASK   = 8'h60;
   localparam logic [7:0] OFS_STAT   = 8'h64;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_FILL,
      SQ_START,
      SQ_WAIT
   } sq_state_t;
endpackage

// File: rtl/hashfe_bswap.sv
module hashfe_bswap #(
   parameter int WORDS = 5
) (
   input  logic                  en,
   input  logic [WORDS*32-1:0]   din,
   output logic [WORDS*32-1:0]   dout
);
   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         logic [31:0] wi;
         assign wi = din[w*32 +: 32];
         assign dout[w*32 +: 32] = en ? {wi[7:0], wi[15:8], wi[23:16], wi[31:24]} : wi;
      end
   endgenerate
endmodule

// File: rtl/hashfe_seq.sv
module hashfe_seq
   import hashfe_pkg::*;
#(
   parameter int BLK_WORDS = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    ctrl_wr,
   input  logic                    ctrl_ack,
   input  logic                    ctrl_algo,
   input  logic                    ctrl_init,
   input  logic                    ctrl_close,
   input  logic [LEN_W-1:0]        ctrl_len,
   input  logic                    din_wr,
   input  logic [31:0]             din_wdata,
   input  logic                    cnt_wr,
   input  logic [31:0]             cnt_wdata,
   input  logic                    dma_en,
   input  logic                    core_done,
   output logic                    algo_q,
   output logic                    init_q,
   output logic                    close_q,
   output logic [LEN_W-1:0]        len_q,
   output logic                    out_rdy,
   output logic                    in_rdy,
   output logic                    busy,
   output logic                    chunk_done,
   output logic                    core_start,
   output logic [31:0]             core_count,
   output logic [31:0]             digcnt_q,
   output logic [BLK_WORDS*32-1:0] core_block,
   output logic                    dma_req
);
   localparam int CNT_W = $clog2(BLK_WORDS + 1);
   localparam int IDX_W = $clog2(BLK_WORDS);
   localparam logic [LEN_W:0]   BLK_CAP = (LEN_W+1)'(BLK_WORDS);
   localparam logic [CNT_W-1:0] BLK_CNT = CNT_W'(BLK_WORDS);

   generate
      if (BLK_WORDS < 2 || BLK_WORDS > WIN_WORDS) begin : g_bad_blk
         $error("hashfe_seq: BLK_WORDS out of range");
      end
   endgenerate

   sq_state_t        state;
   logic [CNT_W-1:0] wcnt, need, need_next;
   logic [LEN_W:0]   words_raw;
   logic [31:0]      base;
   logic [31:0]      blk [BLK_WORDS];
   logic [IDX_W-1:0] wr_idx;

   assign words_raw = ({1'b0, ctrl_len} + (LEN_W+1)'(3)) >> 2;
   assign need_next = (words_raw > BLK_CAP) ? BLK_CNT : words_raw[CNT_W-1:0];
   assign wr_idx    = wcnt[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         algo_q   <= 1'b0;
         init_q   <= 1'b0;
         close_q  <= 1'b0;
         len_q    <= '0;
         out_rdy  <= 1'b0;
         digcnt_q <= '0;
         base     <= '0;
         need     <= '0;
         wcnt     <= '0;
         for (int i = 0; i < BLK_WORDS; i++) blk[i] <= '0;
      end else if (clr) begin
         state    <= SQ_IDLE;
         algo_q   <= 1'b0;
         init_q   <= 1'b0;
         close_q  <= 1'b0;
         len_q    <= '0;
         out_rdy  <= 1'b0;
         digcnt_q <= '0;
         base     <= '0;
         need     <= '0;
         wcnt     <= '0;
         for (int i = 0; i < BLK_WORDS; i++) blk[i] <= '0;
      end else begin
         if (ctrl_wr && ctrl_ack) out_rdy <= 1'b0;
         if (cnt_wr) digcnt_q <= cnt_wdata;
         case (state)
            SQ_IDLE: if (ctrl_wr) begin
               algo_q  <= ctrl_algo;
               init_q  <= ctrl_init;
               close_q <= ctrl_close;
               len_q   <= ctrl_len;
               base    <= ctrl_init ? 32'd0 : digcnt_q;
               need    <= need_next;
               wcnt    <= '0;
               for (int i = 0; i < BLK_WORDS; i++) blk[i] <= '0;
               if (ctrl_len != '0) state <= SQ_FILL;
            end
            SQ_FILL: if (din_wr) begin
               blk[wr_idx] <= din_wdata;
               wcnt        <= wcnt + CNT_W'(1);
               if ((wcnt + CNT_W'(1)) == need) state <= SQ_START;
            end
            SQ_START: state <= SQ_WAIT;
            SQ_WAIT: if (core_done) begin
               state    <= SQ_IDLE;
               out_rdy  <= 1'b1;
               digcnt_q <= base + 32'(len_q);
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign in_rdy     = (state == SQ_FILL);
   assign busy       = (state != SQ_IDLE);
   assign core_start = (state == SQ_START);
   assign chunk_done = (state == SQ_WAIT) && core_done;
   assign dma_req    = in_rdy && dma_en;
   assign core_count = base;

   generate
      for (genvar k = 0; k < BLK_WORDS; k++) begin : g_flat
         assign core_block[k*32 +: 32] = blk[k];
      end
   endgenerate

   assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n || clr)
      core_start |=> !core_start);
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (state == SQ_FILL) |-> (wcnt < need));
   assert_ready_cause_R7: assert property (@(posedge clk) disable iff (!rst_n || clr)
      $rose(out_rdy) |-> $past(core_done));
   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (busy && ctrl_wr) |=> ($stable(len_q) && $stable(algo_q) && $stable(close_q)));
endmodule

// File: rtl/hashfe_top.sv
module hashfe_top
   import hashfe_pkg::*;
#(
   parameter int         ADDR_W     = 8,
   parameter int         BLK_WORDS  = 16,
   parameter int         RST_CYCLES = 8,
   parameter logic [3:0] REV_MAJOR  = 4'h2,
   parameter logic [3:0] REV_MINOR  = 4'h1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   output logic                    irq,
   output logic                    dma_req,
   output logic                    core_start,
   output logic                    core_algo,
   output logic                    core_init,
   output logic                    core_close,
   output logic [LEN_W-1:0]        core_len,
   output logic [31:0]             core_count,
   output logic [DIG_WORDS*32-1:0] core_digest_in,
   output logic [BLK_WORDS*32-1:0] core_block,
   input  logic                    core_done,
   input  logic [DIG_WORDS*32-1:0] core_digest_out
);
   localparam int RST_W    = $clog2(RST_CYCLES + 1);
   localparam int DIG_BITS = DIG_WORDS * 32;

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("hashfe_top: ADDR_W too narrow for the register map");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("hashfe_top: RST_CYCLES must be positive");
      end
   endgenerate

   logic                 hit_ctrl, hit_cnt, hit_din, hit_rev, hit_mask, hit_stat;
   logic [DIG_WORDS-1:0] hit_dig;
   logic                 mask_wr, clr;
   logic [RST_W-1:0]     srst_cnt;
   logic                 autoidle_q, irq_en_q, dma_en_q;
   logic [31:0]          dig [DIG_WORDS];
   logic [DIG_BITS-1:0]  dig_flat, dig_new;
   logic                 algo_q, init_q, close_q, out_rdy, in_rdy, busy, chunk_done;
   logic [LEN_W-1:0]     len_q;
   logic [31:0]          digcnt_q;
   int                   n_upd;

   assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_cnt  = (bus_addr == ADDR_W'(OFS_COUNT));
   assign hit_rev  = (bus_addr == ADDR_W'(OFS_REV));
   assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
   assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_din  = (bus_addr >= ADDR_W'(OFS_DIN)) &&
                     (bus_addr < ADDR_W'(OFS_DIN + 4*WIN_WORDS)) &&
                     (bus_addr[1:0] == 2'b00);

   generate
      for (genvar i = 0; i < DIG_WORDS; i++) begin : g_dig
         assign hit_dig[i] = (bus_addr == ADDR_W'(OFS_DIGEST + 4*i));
         assign dig_flat[i*32 +: 32] = dig[i];
      end
   endgenerate

   assign mask_wr = bus_wr && hit_mask;
   assign clr     = (srst_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_cnt   <= '0;
         autoidle_q <= 1'b0;
         irq_en_q   <= 1'b0;
         dma_en_q   <= 1'b0;
      end else if (mask_wr && bus_wdata[1]) begin
         srst_cnt   <= RST_W'(RST_CYCLES);
         autoidle_q <= 1'b0;
         irq_en_q   <= 1'b0;
         dma_en_q   <= 1'b0;
      end else if (clr) begin
         srst_cnt   <= srst_cnt - RST_W'(1);
      end else if (mask_wr) begin
         autoidle_q <= bus_wdata[0];
         irq_en_q   <= bus_wdata[2];
         dma_en_q   <= bus_wdata[3];
      end
   end

   assign n_upd = algo_q ? DIG_WORDS : DIG_WORDS - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DIG_WORDS; i++) dig[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < DIG_WORDS; i++) dig[i] <= '0;
      end else begin
         for (int i = 0; i < DIG_WORDS; i++) begin
            if (chunk_done && (i < n_upd)) dig[i] <= dig_new[i*32 +: 32];
            else if (bus_wr && hit_dig[i]) dig[i] <= bus_wdata;
         end
      end
   end

   hashfe_bswap #(.WORDS(DIG_WORDS)) i_swap_out (
      .en(algo_q), .din(dig_flat), .dout(core_digest_in));
   hashfe_bswap #(.WORDS(DIG_WORDS)) i_swap_in (
      .en(algo_q), .din(core_digest_out), .dout(dig_new));

   hashfe_seq #(.BLK_WORDS(BLK_WORDS)) i_seq (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .ctrl_wr(bus_wr && hit_ctrl), .ctrl_ack(bus_wdata[0]),
      .ctrl_algo(bus_wdata[2]), .ctrl_init(bus_wdata[3]),
      .ctrl_close(bus_wdata[4]), .ctrl_len(bus_wdata[31:5]),
      .din_wr(bus_wr && hit_din), .din_wdata(bus_wdata),
      .cnt_wr(bus_wr && hit_cnt), .cnt_wdata(bus_wdata),
      .dma_en(dma_en_q), .core_done(core_done),
      .algo_q(algo_q), .init_q(init_q), .close_q(close_q), .len_q(len_q),
      .out_rdy(out_rdy), .in_rdy(in_rdy), .busy(busy), .chunk_done(chunk_done),
      .core_start(core_start), .core_count(core_count), .digcnt_q(digcnt_q),
      .core_block(core_block), .dma_req(dma_req));

   assign core_algo  = algo_q;
   assign core_init  = init_q;
   assign core_close = close_q;
   assign core_len   = len_q;
   assign irq        = out_rdy && irq_en_q;

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) bus_rdata = {len_q, close_q, init_q, algo_q, in_rdy, out_rdy};
      if (hit_cnt)  bus_rdata = digcnt_q;
      if (hit_rev)  bus_rdata = {24'd0, REV_MAJOR, REV_MINOR};
      if (hit_mask) bus_rdata = {28'd0, dma_en_q, irq_en_q, 1'b0, autoidle_q};
      if (hit_stat) bus_rdata = {31'd0, !clr};
      for (int i = 0; i < DIG_WORDS; i++)
         if (hit_dig[i]) bus_rdata = dig[i];
   end

   assert_srst_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr && bus_wdata[1]) |=> clr);
   assert_md5_word4_R6: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (chunk_done && !algo_q && !(bus_wr && hit_dig[DIG_WORDS-1]))
      |=> $stable(dig[DIG_WORDS-1]));
   assert_busy_flag_R3: assert property (@(posedge clk) disable iff (!rst_n || clr)
      in_rdy |-> busy);
endmodule

// File: tb/test_hashfe_top.sv
module test_hashfe_top;
   localparam int BLK = 16;
   localparam int RSTC = 8;
   localparam logic [7:0] A_CNT = 8'h14, A_CTRL = 8'h18, A_DIN = 8'h1C,
                          A_REV = 8'h5C, A_MASK = 8'h60, A_STAT = 8'h64;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic irq, dma_req, core_start, core_algo, core_init, core_close, core_done;
   logic [26:0] core_len;
   logic [31:0] core_count;
   logic [159:0] core_digest_in, core_digest_out;
   logic [BLK*32-1:0] core_block;
   int n_chk = 0, n_err = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   hashfe_top #(.BLK_WORDS(BLK), .RST_CYCLES(RSTC)) i_hashfe_top (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req),
      .core_start(core_start), .core_algo(core_algo), .core_init(core_init),
      .core_close(core_close), .core_len(core_len), .core_count(core_count),
      .core_digest_in(core_digest_in), .core_block(core_block),
      .core_done(core_done), .core_digest_out(core_digest_out));

   // Behavioural core: fixed latency, digest word i = seed + block sum + count + i
   function automatic logic [31:0] bsum(input logic [BLK*32-1:0] b);
      logic [31:0] s = '0;
      for (int i = 0; i < BLK; i++) s += b[i*32 +: 32];
      return s;
   endfunction
   function automatic logic [31:0] swap(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   int stub_cnt = 0;
   logic stub_done = 1'b0;
   logic [159:0] stub_out = '0;
   always @(posedge clk) begin
      stub_done <= (stub_cnt == 1);
      if (core_start) begin
         stub_cnt <= 3;
         for (int i = 0; i < 5; i++)
            stub_out[i*32 +: 32] <= (core_init ? 32'h0100_0000 * (i + 1) : core_digest_in[i*32 +: 32])
                                    + bsum(core_block) + core_count + 32'(i);
      end else if (stub_cnt != 0) stub_cnt <= stub_cnt - 1;
   end
   assign core_done = stub_done;
   assign core_digest_out = stub_out;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask
   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(A_CTRL, d); chk("R1 ctrl after reset", d, 32'h0);
      rd(A_STAT, d); chk("R1 status after reset", d, 32'h1);
      rd(A_REV, d);  chk("R1 R2 revision", d, 32'h21);
      chk("R1 irq low", {31'd0, irq}, 32'h0);
      chk("R1 dma_req low", {31'd0, dma_req}, 32'h0);
   endtask

   task automatic t_zero_len;
      logic [31:0] d;
      wr(A_CTRL, 32'h0000_0004);
      rd(A_CTRL, d); chk("R3 zero length stays idle", d, 32'h0000_0004);
   endtask

   task automatic t_sha_first;
      logic [31:0] d, s, m;
      s = '0;
      wr(A_CTRL, (32'd20 << 5) | 32'h0C);
      rd(A_CTRL, d); chk("R3 input-ready after start", d & 32'h2, 32'h2);
      chk("R8 dma_req low without enable", {31'd0, dma_req}, 32'h0);
      for (int i = 0; i < 5; i++) begin
         wr(A_DIN + 8'(4 * (4 - i)), 32'hA000_0000 + 32'(i));
         s += 32'hA000_0000 + 32'(i);
         if (i == 3) chk("R4 no start before last word", {31'd0, core_start}, 32'h0);
      end
      chk("R4 start after last word", {31'd0, core_start}, 32'h1);
      chk("R4 block word 4", core_block[4*32 +: 32], 32'hA000_0004);
      chk("R4 block word 0", core_block[31:0], 32'hA000_0000);
      chk("R5 init set", {31'd0, core_init}, 32'h1);
      chk("R5 count zero with init", core_count, 32'h0);
      chk("R11 algo SHA-1", {31'd0, core_algo}, 32'h1);
      chk("R11 close clear", {31'd0, core_close}, 32'h0);
      chk("R2 length field", 32'(core_len), 32'd20);
      rd(A_CTRL, d); chk("R4 input-ready drops", d & 32'h2, 32'h0);
      idle(1);
      chk("R4 start is one cycle", {31'd0, core_start}, 32'h0);
      wr(A_DIN, 32'hDEAD_BEEF);
      chk("R4 extra word ignored", core_block[5*32 +: 32], 32'h0);
      idle(8);
      for (int i = 0; i < 5; i++) begin
         m = 32'h0100_0000 * 32'(i + 1) + s + 32'(i);
         rd(8'(4 * i), d); chk("R6 SHA-1 digest byte-reversed", d, swap(m));
      end
      rd(A_CNT, d); chk("R5 byte count after chunk", d, 32'd20);
      rd(A_CTRL, d); chk("R7 output-ready set", d & 32'h1, 32'h1);
      chk("R7 irq masked", {31'd0, irq}, 32'h0);
      wr(A_MASK, 32'h4);
      chk("R7 irq with enable", {31'd0, irq}, 32'h1);
      wr(A_CTRL, 32'h1);
      rd(A_CTRL, d); chk("R7 output-ready cleared", d & 32'h1, 32'h0);
      chk("R7 irq dropped", {31'd0, irq}, 32'h0);
   endtask

   task automatic t_md5_resume;
      logic [31:0] d, s;
      for (int i = 0; i < 5; i++) wr(8'(4 * i), 32'hC0DE_0000 + 32'(i));
      wr(A_CNT, 32'd100);
      wr(A_MASK, 32'hC);
      wr(A_CTRL, (32'd7 << 5) | 32'h10);
      chk("R8 dma_req while awaiting words", {31'd0, dma_req}, 32'h1);
      chk("R6 MD5 digest to core unchanged", core_digest_in[31:0], 32'hC0DE_0000);
      wr(A_CTRL, (32'd60 << 5) | 32'h0C);
      rd(A_CTRL, d); chk("R9 busy control write ignored", d, (32'd7 << 5) | 32'h12);
      wr(A_DIN + 8'h3C, 32'h1234_5678);
      chk("R8 dma_req holds mid-chunk", {31'd0, dma_req}, 32'h1);
      wr(A_DIN, 32'h0000_00AB);
      s = 32'h1234_5678 + 32'h0000_00AB;
      chk("R8 dma_req drops", {31'd0, dma_req}, 32'h0);
      chk("R5 count restored", core_count, 32'd100);
      chk("R11 close set", {31'd0, core_close}, 32'h1);
      chk("R11 algo MD5", {31'd0, core_algo}, 32'h0);
      idle(8);
      for (int i = 0; i < 4; i++) begin
         rd(8'(4 * i), d);
         chk("R6 MD5 digest word", d, 32'hC0DE_0000 + 32'(i) + s + 32'd100 + 32'(i));
      end
      rd(8'h10, d); chk("R6 MD5 leaves word 4", d, 32'hC0DE_0004);
      rd(A_CNT, d); chk("R5 count advances", d, 32'd107);
      chk("R7 irq raised", {31'd0, irq}, 32'h1);
   endtask

   task automatic t_cap;
      logic [31:0] d;
      wr(A_CTRL, (32'd100 << 5) | 32'h0D);
      for (int i = 0; i < 15; i++) wr(A_DIN + 8'(4 * i), 32'(i + 1));
      rd(A_CTRL, d); chk("R4 cap still awaiting 16th", d & 32'h2, 32'h2);
      chk("R4 no start at 15 words", {31'd0, core_start}, 32'h0);
      wr(A_DIN, 32'h10);
      chk("R4 start at 16 words", {31'd0, core_start}, 32'h1);
      chk("R4 16th word placed", core_block[15*32 +: 32], 32'h10);
      idle(8);
      rd(A_CNT, d); chk("R5 init resets count", d, 32'd100);
   endtask

   task automatic t_srst;
      logic [31:0] d;
      wr(A_MASK, 32'h2);
      rd(A_STAT, d); chk("R10 status busy", d, 32'h0);
      idle(RSTC - 1);
      rd(A_STAT, d); chk("R10 status still busy", d, 32'h0);
      idle(1);
      rd(A_STAT, d); chk("R10 status done", d, 32'h1);
      rd(A_MASK, d); chk("R10 mask cleared", d, 32'h0);
      rd(A_CTRL, d); chk("R10 control cleared", d, 32'h0);
      rd(8'h00, d);  chk("R10 digest cleared", d, 32'h0);
      rd(A_CNT, d);  chk("R10 count cleared", d, 32'h0);
      chk("R10 irq low", {31'd0, irq}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_zero_len;
      t_sha_first;
      t_md5_resume;
      t_cap;
      t_srst;
      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule